// File: doc/BRIEF.md
# Double-Data-Rate Write Serializer

This block sits at the end of a memory controller's write path. Each core clock cycle it takes one word of twice the pin width. It sends that word out as two pin-width beats, one in each half of the core cycle. A per-byte mask travels with the data in the same order. The block also produces the intermittent write strobe and one output enable for the shared bidirectional data and strobe lines. The enable is asserted only while a write burst is being framed.

The block runs on a single clock at twice the core rate, so that each half-cycle is one register stage. It keeps its own half-cycle phase and shows it to the core logic on `coreSlot`. Core inputs are taken only on the fast edges where `coreSlot` is high. The core raises `burstOn` one core cycle before its first data word. That cycle becomes the strobe preamble. Dropping `burstOn` ends the burst with a half-cycle postamble, and then the lines are released.

The strobe pattern is produced at half-cycle resolution. In every data cycle its rising edge coincides with the start of the first beat. A fixed quarter-cycle delay after this block, which is not part of it, moves the strobe edges to the middle of each beat.

Top module: `ddr_wr_serializer`

## Requirements
- R1: `coreSlot` is high during reset and toggles on every `clk2x` rising edge afterwards. `burstOn`, `wordValid`, `wordData` and `wordMask` are sampled only on edges where `coreSlot` is high. Values presented on the other edges have no effect.
- R2: While `rst_n` is low, the outputs are: `padOe`=0, `padDqs`=0, `padDq`=0, `padDm` all ones.
- R3: A word sampled with `wordValid`=1 in a data cycle appears at the pins after the next core edge. Bits [BEAT_W-1:0] go out in the first half-cycle and bits [2*BEAT_W-1:BEAT_W] in the second half-cycle.
- R4: `wordMask` bits [MASK_W-1:0] go out on `padDm` with the lower beat, and bits [2*MASK_W-1:MASK_W] with the upper beat. A mask bit of 1 marks its byte as not to be written.
- R5: A core cycle where `burstOn` is sampled high after being low is a preamble. For both halves of that cycle the pins show `padOe`=1 and `padDqs`=0. `wordValid` in that cycle is ignored: `padDq` is 0 and `padDm` is all ones.
- R6: A data cycle is a core cycle where `burstOn` is sampled high in it and in the cycle before. In a data cycle `padDqs` is 1 in the first half and 0 in the second half. `padDqs` is never high while `coreSlot` is high.
- R7: In a data cycle with `wordValid`=0, the strobe keeps toggling, `padDq` is 0 and `padDm` is all ones.
- R8: A core cycle where `burstOn` is sampled low after being high is a postamble. Its first half shows `padOe`=1 and `padDqs`=0. Its second half shows `padOe`=0.
- R9: Outside preamble, data and postamble cycles, `padOe` is 0, `padDq` is 0 and `padDm` is all ones, even when `wordValid` is high.
- R10: When `burstOn` is low for exactly one core cycle between two bursts, a postamble is followed directly by a preamble.
- R11: `padDqs` is high only while `padOe` is high. `padOe` goes low only after a half-cycle with `padDqs` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the core rate; one period is one half core cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| burstOn | input | 1 | Write burst framing from the core, sampled at core edges |
| wordValid | input | 1 | Qualifies `wordData` and `wordMask` at a core edge |
| wordData | input | 2*BEAT_W | Write word; lower half goes out first |
| wordMask | input | 2*BEAT_W/8 | Per-byte write mask for both beats, 1 = masked |
| coreSlot | output | 1 | High on the fast cycles whose closing edge is a core edge |
| padDq | output | BEAT_W | Serialized data beat toward the pad |
| padDm | output | BEAT_W/8 | Serialized byte mask toward the pad |
| padDqs | output | 1 | Write strobe level before the quarter-cycle shift |
| padOe | output | 1 | Output enable for the shared data and strobe lines |

## Verification
The state that matters is the half-cycle phase and the two-deep history of `burstOn`. A wrong phase shows within one fast cycle: the halves of a word come out swapped, or the inputs are taken on the wrong edges. A corrupted history first shows at the next core edge, as a missing preamble, an extra strobe pulse, or `padOe` falling while the strobe is high. A stale or misrouted upper-half register shows one half-cycle after the affected core edge, as a wrong upper beat or mask. The bench compares every pin on every fast cycle, so each of these faults is reported at the first cycle where it shows.

// File: rtl/ddrws_pkg.sv
package ddrws_pkg;

  // Role of one core cycle on the pin side
  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_PRE  = 2'd1,
    KIND_DATA = 2'd2,
    KIND_POST = 2'd3
  } slotKind_e;

  // Per-half-cycle strobes from control to datapath
  typedef struct packed {
    logic capture;    // core edge: sample core inputs
    logic firstHalf;  // this edge launches the first beat
    logic oe;         // pin enable for the coming half-cycle
    logic strobeLvl;  // strobe level for the coming half-cycle
    logic passData;   // beat may carry a valid word
  } laneCtl_t;

endpackage

// File: rtl/ddrws_ctrl.sv
module ddrws_ctrl
  import ddrws_pkg::*;
(
  input  logic     clk2x,
  input  logic     rst_n,
  input  logic     burstOn,
  output logic     coreSlot,
  output laneCtl_t ctl
);

  logic      phase;
  logic      onNow;
  logic      onPrev;
  slotKind_e kindQ;
  slotKind_e kindNext;

  assign coreSlot = ~phase;

  always_comb begin
    unique case ({onNow, onPrev})
      2'b10:   kindNext = KIND_PRE;
      2'b11:   kindNext = KIND_DATA;
      2'b01:   kindNext = KIND_POST;
      default: kindNext = KIND_IDLE;
    endcase
  end

  always_ff @(posedge clk2x) begin
    if (!rst_n) begin
      phase  <= 1'b0;
      onNow  <= 1'b0;
      onPrev <= 1'b0;
      kindQ  <= KIND_IDLE;
    end else begin
      phase <= ~phase;
      if (!phase) begin
        onNow  <= burstOn;
        onPrev <= onNow;
        kindQ  <= kindNext;
      end
    end
  end

  always_comb begin
    ctl.capture   = ~phase;
    ctl.firstHalf = ~phase;
    if (!phase) begin
      ctl.oe        = (kindNext != KIND_IDLE);
      ctl.strobeLvl = (kindNext == KIND_DATA);
      ctl.passData  = (kindNext == KIND_DATA);
    end else begin
      ctl.oe        = (kindQ == KIND_PRE) || (kindQ == KIND_DATA);
      ctl.strobeLvl = 1'b0;
      ctl.passData  = (kindQ == KIND_DATA);
    end
  end

endmodule

// File: rtl/ddrws_path.sv
module ddrws_path
  import ddrws_pkg::*;
#(
  parameter int BEAT_W = 16
) (
  input  logic                  clk2x,
  input  logic                  rst_n,
  input  laneCtl_t              ctl,
  input  logic                  wordValid,
  input  logic [2*BEAT_W-1:0]   wordData,
  input  logic [BEAT_W/4-1:0]   wordMask,
  output logic [BEAT_W-1:0]     padDq,
  output logic [BEAT_W/8-1:0]   padDm,
  output logic                  padDqs,
  output logic                  padOe
);

  localparam int MASK_W = BEAT_W / 8;

  logic                validA;
  logic [2*BEAT_W-1:0] dataA;
  logic [2*MASK_W-1:0] maskA;
  logic                validHi;
  logic [BEAT_W-1:0]   dataHi;
  logic [MASK_W-1:0]   maskHi;

  logic                beatValid;
  logic [BEAT_W-1:0]   beatData;
  logic [MASK_W-1:0]   beatMask;
  logic                carry;

  always_comb begin
    beatValid = ctl.firstHalf ? validA               : validHi;
    beatData  = ctl.firstHalf ? dataA[BEAT_W-1:0]    : dataHi;
    beatMask  = ctl.firstHalf ? maskA[MASK_W-1:0]    : maskHi;
    carry     = ctl.passData && beatValid;
  end

  always_ff @(posedge clk2x) begin
    if (!rst_n) begin
      validA  <= 1'b0;
      dataA   <= '0;
      maskA   <= '1;
      validHi <= 1'b0;
      dataHi  <= '0;
      maskHi  <= '1;
      padDq   <= '0;
      padDm   <= '1;
      padDqs  <= 1'b0;
      padOe   <= 1'b0;
    end else begin
      if (ctl.capture) begin
        validA <= wordValid;
        dataA  <= wordData;
        maskA  <= wordMask;
      end
      if (ctl.firstHalf) begin
        validHi <= validA;
        dataHi  <= dataA[2*BEAT_W-1:BEAT_W];
        maskHi  <= maskA[2*MASK_W-1:MASK_W];
      end
      padOe  <= ctl.oe;
      padDqs <= ctl.strobeLvl;
      padDq  <= carry ? beatData : '0;
      padDm  <= carry ? beatMask : '1;
    end
  end

endmodule

// File: rtl/ddr_wr_serializer.sv
module ddr_wr_serializer
  import ddrws_pkg::*;
#(
  parameter int BEAT_W = 16
) (
  input  logic                  clk2x,
  input  logic                  rst_n,
  input  logic                  burstOn,
  input  logic                  wordValid,
  input  logic [2*BEAT_W-1:0]   wordData,
  input  logic [BEAT_W/4-1:0]   wordMask,
  output logic                  coreSlot,
  output logic [BEAT_W-1:0]     padDq,
  output logic [BEAT_W/8-1:0]   padDm,
  output logic                  padDqs,
  output logic                  padOe
);

  laneCtl_t laneCtl;

  ddrws_ctrl u_ctrl (
    .clk2x    (clk2x),
    .rst_n    (rst_n),
    .burstOn  (burstOn),
    .coreSlot (coreSlot),
    .ctl      (laneCtl)
  );

  ddrws_path #(.BEAT_W(BEAT_W)) u_path (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .ctl       (laneCtl),
    .wordValid (wordValid),
    .wordData  (wordData),
    .wordMask  (wordMask),
    .padDq     (padDq),
    .padDm     (padDm),
    .padDqs    (padDqs),
    .padOe     (padOe)
  );

endmodule

// File: rtl/ddrws_chk.sv
module ddrws_chk #(
  parameter int BEAT_W = 16
) (
  input logic                clk2x,
  input logic                rst_n,
  input logic                coreSlot,
  input logic [BEAT_W-1:0]   padDq,
  input logic [BEAT_W/8-1:0] padDm,
  input logic                padDqs,
  input logic                padOe
);

  // R1
  slot_fall_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    coreSlot |=> !coreSlot);

  // R1
  slot_rise_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    !coreSlot |=> coreSlot);

  // R11
  strobe_needs_oe_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    padDqs |-> padOe);

  // R6
  strobe_pulse_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    padDqs |=> !padDqs);

  // R6
  strobe_first_half_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    padDqs |-> !coreSlot);

  // R8
  postamble_low_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    $fell(padOe) |-> !$past(padDqs));

  // R5
  preamble_lead_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(padDqs) |-> $past(padOe));

  // R9
  released_quiet_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    !padOe |-> (padDq == '0 && padDm == '1));

endmodule

bind ddr_wr_serializer ddrws_chk #(.BEAT_W(BEAT_W)) u_chk (
  .clk2x    (clk2x),
  .rst_n    (rst_n),
  .coreSlot (coreSlot),
  .padDq    (padDq),
  .padDm    (padDm),
  .padDqs   (padDqs),
  .padOe    (padOe)
);

// File: tb/sim_ddr_wr_serializer.sv
module sim_ddr_wr_serializer;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 16;
  localparam int MW = BW / 8;
  localparam int NC = 64;
  localparam logic [63:0] ON_PAT = 64'h5A3C96E1_FFF37BC8;

  logic            clk2x = 1'b0;
  logic            rst_n;
  logic            burstOn;
  logic            wordValid;
  logic [2*BW-1:0] wordData;
  logic [2*MW-1:0] wordMask;
  logic            coreSlot;
  logic [BW-1:0]   padDq;
  logic [MW-1:0]   padDm;
  logic            padDqs;
  logic            padOe;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic            onS [NC];
  logic            vS  [NC];
  logic [2*BW-1:0] dS  [NC];
  logic [2*MW-1:0] mS  [NC];

  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  ddr_wr_serializer #(.BEAT_W(BW)) u0 (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .burstOn   (burstOn),
    .wordValid (wordValid),
    .wordData  (wordData),
    .wordMask  (wordMask),
    .coreSlot  (coreSlot),
    .padDq     (padDq),
    .padDm     (padDm),
    .padDqs    (padDqs),
    .padOe     (padOe)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk2x);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < NC; j++) begin
      onS[j] = ON_PAT[j];
      vS[j]  = ((j * 5) % 7) != 3;
      dS[j]  = (32'(j) + 32'd1) * 32'h9E3779B9;
      mS[j]  = 4'(j * 3);
    end

    rst_n = 1'b0; burstOn = 1'b1; wordValid = 1'b1;
    wordData = '1; wordMask = '0;
    repeat (3) @(posedge clk2x);
    @(negedge clk2x);
    // R2: reset values
    check("R2", "padOe", 32'(padOe), 32'd0);
    check("R2", "padDqs", 32'(padDqs), 32'd0);
    check("R2", "padDq", 32'(padDq), 32'd0);
    check("R2", "padDm", 32'(padDm), 32'(2'b11));
    // R1: phase in reset
    check("R1", "coreSlot", 32'(coreSlot), 32'd1);

    rst_n = 1'b1;
    burstOn = onS[0]; wordValid = vS[0]; wordData = dS[0]; wordMask = mS[0];

    for (int t = 0; t < 2 * NC + 4; t++) begin
      int k;
      int hf;
      int kind;
      logic onNow, onPrev, carry;
      logic eOe, eDqs;
      logic [BW-1:0] eDq;
      logic [MW-1:0] eDm;
      string tagK;

      @(posedge clk2x);
      @(negedge clk2x);

      k  = t / 2;
      hf = t % 2;
      onNow  = (k >= 1 && k - 1 < NC) ? onS[k-1] : 1'b0;
      onPrev = (k >= 2 && k - 2 < NC) ? onS[k-2] : 1'b0;
      kind = onNow ? (onPrev ? 2 : 1) : (onPrev ? 3 : 0);
      eOe  = (hf == 0) ? (kind != 0) : (kind == 1 || kind == 2);
      eDqs = (hf == 0) && (kind == 2);
      carry = (kind == 2) && vS[k-1];
      eDq = carry ? ((hf == 0) ? dS[k-1][BW-1:0] : dS[k-1][2*BW-1:BW]) : '0;
      eDm = carry ? ((hf == 0) ? mS[k-1][MW-1:0] : mS[k-1][2*MW-1:MW]) : '1;

      case (kind)
        0: tagK = "R9";
        1: tagK = (k >= 3 && onS[k-3]) ? "R10" : "R5";
        2: tagK = carry ? "R3" : "R7";
        default: tagK = "R8";
      endcase

      // R1: phase after each edge
      check("R1", "coreSlot", 32'(coreSlot), 32'(hf));
      check(tagK, "padOe", 32'(padOe), 32'(eOe));
      check((kind == 2) ? "R6" : tagK, "padDqs", 32'(padDqs), 32'(eDqs));
      check(tagK, "padDq", 32'(padDq), 32'(eDq));
      check(carry ? "R4" : tagK, "padDm", 32'(padDm), 32'(eDm));
      // R11: strobe only with enable
      if (padDqs) check("R11", "padOe with strobe", 32'(padOe), 32'd1);

      if ((t + 1) % 2 == 0) begin
        int j;
        j = (t + 1) / 2;
        if (j < NC) begin
          burstOn = onS[j]; wordValid = vS[j]; wordData = dS[j]; wordMask = mS[j];
        end else begin
          burstOn = 1'b0; wordValid = 1'b0; wordData = '0; wordMask = '0;
        end
      end else begin
        // R1: junk on non-core edges must be ignored
        burstOn = ~burstOn; wordValid = ~wordValid;
        wordData = ~wordData; wordMask = ~wordMask;
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule